// File: doc/BRIEF.md
# Outlier-Preserving Block Quantizer

This block turns a block of BF16 activations into a compact two-part form for a low-precision datapath. Elements arrive one per cycle on a valid/ready stream. While they arrive, the block keeps a sorted shortlist of the largest magnitudes seen so far. The four largest elements are kept as raw BF16 values together with their positions. The fifth largest magnitude is the biggest element left, and it sets one power-of-two scale for the whole block. Every other element is then rounded to a 4-bit signed integer against that scale.

The work is done by a four-state machine. `ST_LOAD` accepts elements and leaves for `ST_SCALE` on the final element. `ST_SCALE` fixes the shared exponent in one cycle and then enters `ST_QUANT`. `ST_QUANT` quantizes one stored element per cycle and moves to `ST_EMIT` after the final index. `ST_EMIT` presents the record until the consumer takes it, then returns to `ST_LOAD` with the shortlist cleared. The input stream is stalled in every state except `ST_LOAD`.

Top module: `mx_outlier_quant`

## Requirements
- R1: With N=128 elements per block, `in_ready` is high throughout `ST_LOAD`, and one element is taken on each rising edge where `in_valid` and `in_ready` are both high. The element position is its order of arrival, starting at 0.
- R2: The outliers are the K=4 elements with the largest magnitude, where magnitude is the unsigned value of bits [14:0]. A tie goes to the lower position. Slot k sits at `out_idx[k*7 +: 7]` and `out_val[k*16 +: 16]`. Slot 0 holds the largest magnitude, and the slots run in non-increasing order. Each value is the raw BF16 input word.
- R3: `out_scale` is a biased 8-bit exponent. It equals E-2, where E is the exponent field (bits [14:7]) of the largest-magnitude non-outlier. If E is below 2, `out_scale` is 0.
- R4: Each non-outlier element i gives `out_ints[i*4 +: 4]`, a two's-complement value. It is the element divided by 2^(out_scale-127), rounded to nearest with ties to even, and saturated to -8..7. An element whose exponent field is 0 gives 0.
- R5: The 4-bit integer slot at each outlier position is 0.
- R6: `out_valid` rises N+1 rising edges after the edge that accepted the final element of a block.
- R7: `in_ready` stays low from the edge that takes the final element until the record is taken. While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R8: A block of all zeros gives `out_scale` 0, all-zero integers, and outlier slots 0..3 with positions 0..3 and value 0.
- R9: The edge where `out_valid` and `out_ready` are both high ends the record. `out_valid` is low and `in_ready` is high after that edge. The next block is handled without any state left over from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input element is present |
| in_ready | output | 1 | Block accepts an element |
| in_data | input | 16 | BF16 element |
| out_valid | output | 1 | Record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_scale | output | 8 | Shared biased exponent |
| out_idx | output | K*7 = 28 | Outlier positions, slot 0 in the low bits |
| out_val | output | K*16 = 64 | Outlier BF16 values, slot 0 in the low bits |
| out_ints | output | N*4 = 512 | 4-bit integers, element 0 in the low bits |

## Verification
The final element is accepted on edge 0. `in_ready` is already low when the bench samples one time unit after that edge. The bench then counts edges until it first sees `out_valid`, and it expects exactly N+1. The whole record is compared in that first valid cycle, against a value the bench builds from a selection sort and real-number rounding. The bench then holds `out_ready` low for a few cycles and samples after each edge to confirm the record does not change. It checks the release one unit after the edge on which the record is taken.

// File: rtl/mx_oq_pkg.sv
package mx_oq_pkg;
    localparam int BF_W = 16;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_SCALE,
        ST_QUANT,
        ST_EMIT
    } oq_state_e;
endpackage

// File: rtl/mx_oq_topk.sv
module mx_oq_topk #(
    parameter int N    = 128,
    parameter int K    = 4,
    parameter int IDXW = $clog2(N)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        ins_en,
    input  logic [15:0]                 ins_val,
    input  logic [IDXW-1:0]             ins_idx,
    output logic [K-1:0][15:0]          top_val,
    output logic [K-1:0][IDXW-1:0]      top_idx,
    output logic [K-1:0]                top_vld,
    output logic [7:0]                  next_exp
);
    localparam int S = K + 1;

    logic [S-1:0][15:0]     sv;
    logic [S-1:0][IDXW-1:0] si;
    logic [S-1:0]           vl;
    logic [S-1:0]           beats;

    for (genvar j = 0; j < S; j++) begin : g_slot
        assign beats[j] = !vl[j] || (ins_val[14:0] > sv[j][14:0]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vl[j] <= 1'b0;
                sv[j] <= '0;
                si[j] <= '0;
            end else if (clear) begin
                vl[j] <= 1'b0;
            end else if (ins_en && beats[j]) begin
                if (j == 0) begin
                    sv[j] <= ins_val;
                    si[j] <= ins_idx;
                    vl[j] <= 1'b1;
                end else if (beats[(j == 0) ? 0 : j-1]) begin
                    sv[j] <= sv[(j == 0) ? 0 : j-1];
                    si[j] <= si[(j == 0) ? 0 : j-1];
                    vl[j] <= vl[(j == 0) ? 0 : j-1];
                end else begin
                    sv[j] <= ins_val;
                    si[j] <= ins_idx;
                    vl[j] <= 1'b1;
                end
            end
        end
    end

    for (genvar k = 0; k < K; k++) begin : g_out
        assign top_val[k] = sv[k];
        assign top_idx[k] = si[k];
        assign top_vld[k] = vl[k];
    end

    assign next_exp = vl[K] ? sv[K][14:7] : 8'd0;
endmodule

// File: rtl/mx_oq_quant.sv
module mx_oq_quant #(
    parameter int QW = 4
) (
    input  logic [15:0]   x,
    input  logic [7:0]    scale,
    output logic [QW-1:0] q
);
    localparam logic [8:0] PMAX = 9'((2 ** (QW - 1)) - 1);
    localparam logic [8:0] NMAX = PMAX + 9'd1;

    logic [7:0]         ex;
    logic [7:0]         sig;
    logic signed [10:0] r;
    logic [23:0]        sh;
    logic [8:0]         mag;
    logic [8:0]         neg;
    logic               big;

    assign ex  = x[14:7];
    assign sig = {1'b1, x[6:0]};
    assign r   = $signed({3'b000, scale}) + 11'sd7 - $signed({3'b000, ex});

    always_comb begin
        big = 1'b0;
        mag = '0;
        sh  = {sig, 16'h0000} >> r[3:0];
        if (ex == 8'd0) begin
            mag = '0;
        end else if (r < 11'sd0) begin
            big = 1'b1;
        end else if (r > 11'sd15) begin
            mag = '0;
        end else begin
            mag = {1'b0, sh[23:16]}
                + {8'd0, sh[15] && ((|sh[14:0]) || sh[16])};
        end
        neg = 9'd0 - mag;
        if (x[15]) begin
            q = (big || mag > NMAX) ? NMAX[QW-1:0] : neg[QW-1:0];
        end else begin
            q = (big || mag > PMAX) ? PMAX[QW-1:0] : mag[QW-1:0];
        end
    end
endmodule

// File: rtl/mx_outlier_quant.sv
module mx_outlier_quant
    import mx_oq_pkg::*;
#(
    parameter int N  = 128,
    parameter int K  = 4,
    parameter int QW = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [15:0]                 in_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [7:0]                  out_scale,
    output logic [K*$clog2(N)-1:0]      out_idx,
    output logic [K*16-1:0]             out_val,
    output logic [N*QW-1:0]             out_ints
);
    localparam int IDXW = $clog2(N);
    localparam int HEAD = QW - 2;
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

    oq_state_e state_q, state_d;

    logic [IDXW-1:0]        cnt_q;
    logic [BF_W-1:0]        buf_q [N];
    logic [7:0]             scale_q;
    logic [N*QW-1:0]        ints_q;
    logic                   accept;
    logic                   at_last;
    logic                   take;
    logic [K-1:0][15:0]     top_val;
    logic [K-1:0][IDXW-1:0] top_idx;
    logic [K-1:0]           top_vld;
    logic [7:0]             next_exp;
    logic [7:0]             scale_calc;
    logic [QW-1:0]          q_elem;
    logic                   hit;

    assign accept  = in_valid && in_ready;
    assign at_last = (cnt_q == LAST);
    assign take    = out_valid && out_ready;

    mx_oq_topk #(.N(N), .K(K), .IDXW(IDXW)) topk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take),
        .ins_en   (accept),
        .ins_val  (in_data),
        .ins_idx  (cnt_q),
        .top_val  (top_val),
        .top_idx  (top_idx),
        .top_vld  (top_vld),
        .next_exp (next_exp)
    );

    mx_oq_quant #(.QW(QW)) quant_i (
        .x     (buf_q[cnt_q]),
        .scale (scale_q),
        .q     (q_elem)
    );

    assign scale_calc = (next_exp >= 8'(HEAD)) ? next_exp - 8'(HEAD) : 8'd0;

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < K; k++) begin
            if (top_vld[k] && top_idx[k] == cnt_q) hit = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  if (accept && at_last) state_d = ST_SCALE;
            ST_SCALE: state_d = ST_QUANT;
            ST_QUANT: if (at_last) state_d = ST_EMIT;
            ST_EMIT:  if (out_ready) state_d = ST_LOAD;
            default:  state_d = ST_LOAD;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        in_ready  = (state_q == ST_LOAD);
        out_valid = (state_q == ST_EMIT);
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            scale_q <= '0;
            ints_q  <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: if (accept) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
                ST_SCALE: begin
                    scale_q <= scale_calc;
                    cnt_q   <= '0;
                end
                ST_QUANT: begin
                    ints_q[cnt_q*QW +: QW] <= hit ? '0 : q_elem;
                    cnt_q <= at_last ? '0 : cnt_q + 1'b1;
                end
                ST_EMIT: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) buf_q[cnt_q] <= in_data;
    end

    assign out_scale = scale_q;
    assign out_ints  = ints_q;
    for (genvar k = 0; k < K; k++) begin : g_pack
        assign out_idx[k*IDXW +: IDXW] = top_idx[k];
        assign out_val[k*16 +: 16]     = top_val[k];
    end
endmodule

// File: rtl/mx_oq_chk.sv
module mx_oq_chk #(
    parameter int N  = 128,
    parameter int K  = 4,
    parameter int QW = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [7:0]             out_scale,
    input logic [K*$clog2(N)-1:0] out_idx,
    input logic [K*16-1:0]        out_val,
    input logic [N*QW-1:0]        out_ints
);
    localparam int IDXW = $clog2(N);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_scale)
            && $stable(out_idx) && $stable(out_val) && $stable(out_ints));

    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready);

    always @(posedge clk) begin
        if (rst_n && out_valid) begin
            for (int k = 0; k < K; k++) begin
                assert_zero_slot_R5: assert (out_ints[out_idx[k*IDXW +: IDXW]*QW +: QW] == '0);
            end
            for (int k = 0; k < K - 1; k++) begin
                assert_order_R2: assert (out_val[k*16 +: 15] >= out_val[(k+1)*16 +: 15]);
                for (int m = k + 1; m < K; m++) begin
                    assert_distinct_R2: assert (out_idx[k*IDXW +: IDXW] != out_idx[m*IDXW +: IDXW]);
                end
            end
        end
    end
endmodule

bind mx_outlier_quant mx_oq_chk #(.N(N), .K(K), .QW(QW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_scale (out_scale),
    .out_idx   (out_idx),
    .out_val   (out_val),
    .out_ints  (out_ints)
);

// File: tb/mx_outlier_quant_tb.sv
module mx_outlier_quant_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 16;
    localparam int K    = 4;
    localparam int QW   = 4;
    localparam int IDXW = $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [15:0]          in_data = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic [7:0]           out_scale;
    logic [K*IDXW-1:0]    out_idx;
    logic [K*16-1:0]      out_val;
    logic [N*QW-1:0]      out_ints;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [15:0] blk [N];
    int          sel [K+1];
    int          exp_scale;

    always #(CLK_PERIOD/2) clk = ~clk;

    mx_outlier_quant #(.N(N), .K(K), .QW(QW)) dut_i (.*);

    task automatic chk(input string req, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int qref(input logic [15:0] x, input int s);
        int  e;
        int  m;
        real sc;
        real fl;
        real fr;
        e = int'(x[14:7]);
        if (e == 0) return 0;
        sc = real'({1'b1, x[6:0]}) * (2.0 ** (e - s - 7));
        fl = $floor(sc);
        fr = sc - fl;
        m  = int'(fl);
        if (fr > 0.5 || (fr == 0.5 && (m % 2) == 1)) m++;
        if (x[15]) begin
            m = -m;
            if (m < -8) m = -8;
        end else if (m > 7) begin
            m = 7;
        end
        return m;
    endfunction

    task automatic compute_ref();
        bit used [N];
        for (int i = 0; i < N; i++) used[i] = 1'b0;
        for (int s = 0; s <= K; s++) begin
            int best = -1;
            for (int i = 0; i < N; i++) begin
                if (!used[i] && (best < 0 || blk[i][14:0] > blk[best][14:0])) best = i;
            end
            sel[s] = best;
            used[best] = 1'b1;
        end
        exp_scale = int'(blk[sel[K]][14:7]);
        exp_scale = (exp_scale >= 2) ? exp_scale - 2 : 0;
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < N; i++) begin
            logic [7:0] e;
            logic [6:0] mt;
            mt = 7'($urandom);
            case (mode)
                0: e = 8'(118 + $urandom % 20);
                1: begin e = 8'd127; mt = 7'(($urandom % 4) * 32); end
                2: begin e = 8'd0; mt = 7'd0; end
                3: e = 8'(120 + $urandom % 7);
                4: e = ($urandom % 2) ? 8'd0 : 8'(1 + $urandom % 4);
                default: e = 8'(100 + $urandom % 40);
            endcase
            blk[i] = {(mode == 2) ? 1'b0 : 1'($urandom), e, mt};
        end
        if (mode == 3) begin
            for (int j = 0; j < K; j++) blk[$urandom % N][14:7] = 8'(140 + j);
        end
    endtask

    task automatic run_block(input int mode);
        int lat;
        int hold;
        logic [7:0]        s_scale;
        logic [N*QW-1:0]   s_ints;
        string             rs;
        fill(mode);
        compute_ref();
        for (int i = 0; i < N; i++) begin
            while ($urandom % 4 == 0) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = blk[i];
            if (i == 0 || i == N - 1) chk("R1 in_ready in load", int'(in_ready), 1);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        chk("R7 stall after last", int'(in_ready), 0);
        lat = 0;
        while (!out_valid) begin
            @(posedge clk); #1;
            lat++;
        end
        chk("R6 latency", lat, N + 1);
        rs = (mode == 2) ? "R8 zero block scale" : "R3 scale";
        chk(rs, int'(out_scale), exp_scale);
        for (int k = 0; k < K; k++) begin
            chk("R2 outlier index", int'(out_idx[k*IDXW +: IDXW]), sel[k]);
            chk("R2 outlier value", int'(out_val[k*16 +: 16]), int'(blk[sel[k]]));
        end
        for (int i = 0; i < N; i++) begin
            bit is_out = 1'b0;
            for (int k = 0; k < K; k++) if (sel[k] == i) is_out = 1'b1;
            if (is_out)
                chk("R5 outlier slot zero", int'($signed(out_ints[i*QW +: QW])), 0);
            else
                chk("R4 integer element", int'($signed(out_ints[i*QW +: QW])), qref(blk[i], exp_scale));
        end
        s_scale = out_scale;
        s_ints  = out_ints;
        hold = $urandom % 4;
        for (int h = 0; h < hold; h++) begin
            @(posedge clk); #1;
            chk("R7 hold valid", int'(out_valid), 1);
            chk("R7 hold ready low", int'(in_ready), 0);
            chk("R7 hold data", int'(out_ints == s_ints && out_scale == s_scale), 1);
        end
        out_ready = 1'b1;
        @(posedge clk); #1;
        out_ready = 1'b0;
        chk("R9 valid drops", int'(out_valid), 0);
        chk("R9 ready returns", int'(in_ready), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset ready", int'(in_ready), 1);
        chk("R9 reset valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        run_block(2);
        for (int b = 0; b < 180; b++) run_block(b % 6);
        run_block(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule